// File: doc/BRIEF.md
# 4:2:2 Byte-Stream Deinterleaver

This block sits behind an 8-bit video input pin group. It turns a multiplexed byte stream into whole pixels. In luma/chroma mode the stream carries 4:2:2 samples: two chroma bytes are shared by two luma bytes. The block emits one pixel for each luma byte, and both pixels of a pair carry the same blue-difference and red-difference values. In serial RGB mode every three bytes form one pixel. A single order input swaps the two chroma bytes in luma/chroma mode and reverses R and B in RGB mode. A second input reverses the value range of every output component.

The input qualifier `byte_en_i` marks the bytes that count. `line_start_i` marks the first byte of a video line and realigns the byte phase, so that a damaged line does not shift the next one. A line is 640 luma and 320 chroma pairs for the narrow format, or 720 and 360 for the wide one. The phase logic needs no line length, because every line begins with a marker. Each pixel appears on the three component outputs together with a one-cycle `pix_valid_o` pulse. The outputs are registered, so the pulse comes in the cycle after the byte that completes the pixel. The component values hold until the next pulse.

Top module: `ycd_deint`

## Requirements
- R1: While reset is low and right after it is released, `pix_valid_o` is 0 and all three component outputs are 0.
- R2: With `rgb_mode_i`=0 and `order_swap_i`=0, a group of four bytes arrives as Cb, Y0, Cr, Y1. Two pixels come out as (c0=Y, c1=Cb, c2=Cr). The first has Y0 and is valid in the cycle after the Cr byte. The second has Y1 and is valid in the cycle after the Y1 byte. Both use the same Cb and Cr, and the next group brings new chroma.
- R3: With `rgb_mode_i`=0 and `order_swap_i`=1, the group arrives as Cr, Y0, Cb, Y1. The outputs keep the same meaning as in R2: c1 carries Cb and c2 carries Cr.
- R4: With `rgb_mode_i`=1 and `order_swap_i`=0, the bytes arrive as R, G, B. One pixel comes out as (c0=R, c1=G, c2=B) and is valid in the cycle after the third byte.
- R5: With `rgb_mode_i`=1 and `order_swap_i`=1, the bytes arrive as B, G, R. The outputs keep the same meaning as in R4.
- R6: With `range_rev_i`=1 when a pixel completes, every output component is 255 minus its value (all ones minus the value).
- R7: A byte presented with `byte_en_i`=0 has no effect. It does not advance the byte phase, it does not enter any component, and it does not cause a valid pulse.
- R8: `line_start_i`=1 resets the byte phase to the start of a group. If `byte_en_i` is also 1, that byte is the first of the group. If `byte_en_i` is 0, the next enabled byte is the first of the group.
- R9: `pix_valid_o` is high for exactly one cycle per pixel. Between pulses the component outputs keep the last pixel.
- R10: In RGB mode two valid pulses are never in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_i | input | W (8) | Stream byte |
| byte_en_i | input | 1 | Byte qualifier |
| line_start_i | input | 1 | First byte of a line |
| rgb_mode_i | input | 1 | 0: 4:2:2 luma/chroma stream, 1: serial RGB triplets |
| order_swap_i | input | 1 | Swaps the chroma order, or selects BGR byte order in RGB mode |
| range_rev_i | input | 1 | Reverses the value range of all components |
| pix_valid_o | output | 1 | One-cycle pixel strobe |
| pix_c0_o | output | W (8) | Y, or R in RGB mode |
| pix_c1_o | output | W (8) | Cb, or G in RGB mode |
| pix_c2_o | output | W (8) | Cr, or B in RGB mode |

## Verification
The assertions assume that `rgb_mode_i` and `order_swap_i` stay constant within a line. They also assume that the stream keeps to whole groups between line markers, and that only the marker realigns the phase. The stimulus changes mode inputs only in the cycle just before a byte carrying `line_start_i`. It places the disabled bytes and the marker without data deliberately, in the middle of groups. The damaged-line cases break off a group on purpose. The next marker restores alignment before any pixel is judged.

// File: rtl/ycd_pkg.sv
package ycd_pkg;
    localparam int unsigned PH_W = 2;
    typedef logic [PH_W-1:0] phase_t;

    // last byte slot of a group per stream kind
    localparam phase_t LAST_YC  = phase_t'(3);
    localparam phase_t LAST_RGB = phase_t'(2);

    // slot in which a pixel can complete
    localparam phase_t SLOT_PAIR_A = phase_t'(2);
    localparam phase_t SLOT_PAIR_B = phase_t'(3);
endpackage

// File: rtl/ycd_phase_track.sv
module ycd_phase_track
    import ycd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   byte_en_i,
    input  logic   line_start_i,
    input  logic   rgb_i,
    output phase_t phase_o
);
    typedef struct packed {
        phase_t ph;
    } trk_t;

    trk_t   trk_d, trk_q;
    phase_t cur;
    phase_t last;

    always_comb begin
        trk_d = trk_q;
        cur   = line_start_i ? '0 : trk_q.ph;
        last  = rgb_i ? LAST_RGB : LAST_YC;
        if (byte_en_i) begin
            trk_d.ph = (cur >= last) ? '0 : cur + phase_t'(1);
        end else begin
            trk_d.ph = cur;
        end
        phase_o = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_en_i && !line_start_i) |=> $stable(trk_q.ph));

    // R8
    sol_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en_i && line_start_i) |=> (trk_q.ph == phase_t'(1)));

    // R8
    sol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_en_i && line_start_i) |=> (trk_q.ph == '0));
endmodule

// File: rtl/ycd_pair_build.sv
module ycd_pair_build
    import ycd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_en_i,
    input  phase_t       phase_i,
    input  logic         rgb_i,
    input  logic         swap_i,
    input  logic [W-1:0] data_i,
    output logic         emit_o,
    output logic [W-1:0] c0_o,
    output logic [W-1:0] c1_o,
    output logic [W-1:0] c2_o
);
    typedef struct packed {
        logic [W-1:0] head;   // first chroma or first RGB byte
        logic [W-1:0] mid;    // held luma or green
        logic [W-1:0] tail;   // second chroma, kept for the second pixel
    } hold_t;

    hold_t        hold_d, hold_q;
    logic [W-1:0] first_b, mid_b, last_b;
    logic [W-1:0] lo_b, hi_b;

    always_comb begin
        hold_d  = hold_q;
        emit_o  = 1'b0;
        first_b = hold_q.head;
        mid_b   = hold_q.mid;
        last_b  = hold_q.tail;
        if (byte_en_i) begin
            case (phase_i)
                phase_t'(0): hold_d.head = data_i;
                phase_t'(1): hold_d.mid  = data_i;
                SLOT_PAIR_A: begin
                    if (!rgb_i) hold_d.tail = data_i;
                    emit_o = 1'b1;
                    last_b = data_i;
                end
                SLOT_PAIR_B: begin
                    emit_o = !rgb_i;
                    mid_b  = data_i;
                end
                default: ;
            endcase
        end
        lo_b = swap_i ? last_b  : first_b;
        hi_b = swap_i ? first_b : last_b;
        if (rgb_i) begin
            c0_o = lo_b;
            c1_o = mid_b;
            c2_o = hi_b;
        end else begin
            c0_o = mid_b;
            c1_o = lo_b;
            c2_o = hi_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    // R10
    rgb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o && rgb_i) |=> !emit_o);
endmodule

// File: rtl/ycd_range_flip.sv
module ycd_range_flip #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 3
) (
    input  logic           rev_i,
    input  logic [N*W-1:0] comp_i,
    output logic [N*W-1:0] comp_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    for (genvar k = 0; k < N; k++) begin : g_comp
        assign comp_o[k*W +: W] = rev_i ? (FULL - comp_i[k*W +: W]) : comp_i[k*W +: W];
    end
endmodule

// File: rtl/ycd_deint.sv
module ycd_deint
    import ycd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] byte_i,
    input  logic         byte_en_i,
    input  logic         line_start_i,
    input  logic         rgb_mode_i,
    input  logic         order_swap_i,
    input  logic         range_rev_i,
    output logic         pix_valid_o,
    output logic [W-1:0] pix_c0_o,
    output logic [W-1:0] pix_c1_o,
    output logic [W-1:0] pix_c2_o
);
    localparam int unsigned NCOMP = 3;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        logic [W-1:0] c2;
    } out_t;

    out_t             out_d, out_q;
    phase_t           phase;
    logic             emit;
    logic [W-1:0]     raw0, raw1, raw2;
    logic [NCOMP*W-1:0] flat_raw, flat_fix;

    ycd_phase_track i_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_en_i    (byte_en_i),
        .line_start_i (line_start_i),
        .rgb_i        (rgb_mode_i),
        .phase_o      (phase)
    );

    ycd_pair_build #(.W(W)) i_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_en_i (byte_en_i),
        .phase_i   (phase),
        .rgb_i     (rgb_mode_i),
        .swap_i    (order_swap_i),
        .data_i    (byte_i),
        .emit_o    (emit),
        .c0_o      (raw0),
        .c1_o      (raw1),
        .c2_o      (raw2)
    );

    assign flat_raw = {raw2, raw1, raw0};

    ycd_range_flip #(.W(W), .N(NCOMP)) i_flip (
        .rev_i  (range_rev_i),
        .comp_i (flat_raw),
        .comp_o (flat_fix)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = emit;
        if (emit) begin
            out_d.c0 = flat_fix[0 +: W];
            out_d.c1 = flat_fix[W +: W];
            out_d.c2 = flat_fix[2*W +: W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_valid_o = out_q.vld;
    assign pix_c0_o    = out_q.c0;
    assign pix_c1_o    = out_q.c1;
    assign pix_c2_o    = out_q.c2;

    // R7
    valid_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> $past(byte_en_i));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> ($stable(pix_c0_o) && $stable(pix_c1_o) && $stable(pix_c2_o)));
endmodule

// File: tb/test_ycd_deint.sv
`timescale 1ns/1ps
module test_ycd_deint;
    localparam int unsigned W = 8;
    localparam int unsigned WD_CYCLES = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] byte_i = '0;
    logic         byte_en_i = 1'b0;
    logic         line_start_i = 1'b0;
    logic         rgb_mode_i = 1'b0;
    logic         order_swap_i = 1'b0;
    logic         range_rev_i = 1'b0;
    logic         pix_valid_o;
    logic [W-1:0] pix_c0_o, pix_c1_o, pix_c2_o;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ycd_deint #(.W(W)) i_ycd_deint (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_i       (byte_i),
        .byte_en_i    (byte_en_i),
        .line_start_i (line_start_i),
        .rgb_mode_i   (rgb_mode_i),
        .order_swap_i (order_swap_i),
        .range_rev_i  (range_rev_i),
        .pix_valid_o  (pix_valid_o),
        .pix_c0_o     (pix_c0_o),
        .pix_c1_o     (pix_c1_o),
        .pix_c2_o     (pix_c2_o)
    );

    // {flags: rgb,swap,rev in bits 2..0}, {4 stream bytes}, {c0,c1,c2 of pixel 0, c0 of pixel 1}
    localparam logic [71:0] VEC [6] = '{
        72'h00_10203040_20103040,
        72'h02_11223344_22331144,
        72'h01_00FF8001_00FF7FFE,
        72'h04_A1B2C300_A1B2C300,
        72'h06_A1B2C300_C3B2A100,
        72'h07_0FF05500_AA0FF000
    };

    task automatic chk(input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] seen();
        return {pix_valid_o, pix_c0_o, pix_c1_o, pix_c2_o};
    endfunction

    task automatic chk_nv(input string tag);
        chk(tag, {pix_valid_o, 24'h0}, 25'h0);
    endtask

    task automatic put(input logic [7:0] b, input logic en, input logic sol);
        @(negedge clk);
        byte_i       = b;
        byte_en_i    = en;
        line_start_i = sol;
        @(posedge clk);
        #1;
    endtask

    task automatic mode(input logic rgb, input logic swap, input logic rev);
        rgb_mode_i   = rgb;
        order_swap_i = swap;
        range_rev_i  = rev;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", seen(), 25'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", seen(), 25'h0);

        for (int i = 0; i < 6; i++) begin
            logic [71:0] v;
            string       tag;
            v = VEC[i];
            tag = v[64] ? "R6" : (v[66] ? (v[65] ? "R5" : "R4") : (v[65] ? "R3" : "R2"));
            mode(v[66], v[65], v[64]);
            put(v[63:56], 1'b1, 1'b1);
            chk_nv(tag);
            put(v[55:48], 1'b1, 1'b0);
            chk_nv(tag);
            put(v[47:40], 1'b1, 1'b0);
            chk(tag, seen(), {1'b1, v[31:24], v[23:16], v[15:8]});
            if (!v[66]) begin
                put(v[39:32], 1'b1, 1'b0);
                chk(tag, seen(), {1'b1, v[7:0], v[23:16], v[15:8]});
            end
        end

        // R9: strobe drops, last pixel held
        put(8'h00, 1'b0, 1'b0);
        chk("R9 hold", seen(), {1'b0, 8'hAA, 8'h0F, 8'hF0});
        put(8'h00, 1'b0, 1'b0);
        chk("R9 hold 2", seen(), {1'b0, 8'hAA, 8'h0F, 8'hF0});

        // R7: disabled bytes in the middle of a group
        mode(1'b0, 1'b0, 1'b0);
        put(8'h05, 1'b1, 1'b1);
        put(8'h99, 1'b0, 1'b0);
        chk_nv("R7 gap");
        put(8'h06, 1'b1, 1'b0);
        put(8'h99, 1'b0, 1'b0);
        chk_nv("R7 gap 2");
        put(8'h07, 1'b1, 1'b0);
        chk("R7 pixel 0", seen(), {1'b1, 8'h06, 8'h05, 8'h07});
        put(8'h08, 1'b1, 1'b0);
        chk("R7 pixel 1", seen(), {1'b1, 8'h08, 8'h05, 8'h07});

        // R2: next group brings new chroma
        put(8'h21, 1'b1, 1'b0);
        chk_nv("R2 next group");
        put(8'h22, 1'b1, 1'b0);
        put(8'h23, 1'b1, 1'b0);
        chk("R2 new chroma 0", seen(), {1'b1, 8'h22, 8'h21, 8'h23});
        put(8'h24, 1'b1, 1'b0);
        chk("R2 new chroma 1", seen(), {1'b1, 8'h24, 8'h21, 8'h23});

        // R8: marker with data cuts off a broken group
        put(8'h50, 1'b1, 1'b1);
        put(8'h60, 1'b1, 1'b0);
        put(8'h01, 1'b1, 1'b1);
        chk_nv("R8 realign");
        put(8'h02, 1'b1, 1'b0);
        put(8'h03, 1'b1, 1'b0);
        chk("R8 realigned pixel", seen(), {1'b1, 8'h02, 8'h01, 8'h03});

        // R8: marker without data
        put(8'h70, 1'b1, 1'b1);
        put(8'h71, 1'b1, 1'b0);
        put(8'hEE, 1'b0, 1'b1);
        chk_nv("R8 idle marker");
        put(8'h11, 1'b1, 1'b0);
        chk_nv("R8 idle marker first");
        put(8'h12, 1'b1, 1'b0);
        put(8'h13, 1'b1, 1'b0);
        chk("R8 idle marker pixel", seen(), {1'b1, 8'h12, 8'h11, 8'h13});

        // R10: back-to-back RGB triplets
        mode(1'b1, 1'b0, 1'b0);
        put(8'h31, 1'b1, 1'b1);
        put(8'h32, 1'b1, 1'b0);
        put(8'h33, 1'b1, 1'b0);
        chk("R4 stream", seen(), {1'b1, 8'h31, 8'h32, 8'h33});
        put(8'h41, 1'b1, 1'b0);
        chk("R10 no repeat", seen(), {1'b0, 8'h31, 8'h32, 8'h33});
        put(8'h42, 1'b1, 1'b0);
        chk_nv("R10 gap");
        put(8'h43, 1'b1, 1'b0);
        chk("R10 next pixel", seen(), {1'b1, 8'h41, 8'h42, 8'h43});

        // R1: reset again clears outputs
        @(negedge clk);
        byte_en_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 re-reset", seen(), 25'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule